// File: doc/BRIEF.md
# Pipelined Four-Channel ADC Scan Controller

This block is the host-side serial master for a four-input, 12-bit successive-approximation converter on an SPI-style link. Each transfer is one frame of 16 serial clocks with chip select held low. During the frame the master sends a control byte that names the input for the *following* conversion. At the same time it reads in the result of the conversion that was named one frame earlier.

The converter always applies an address one frame late, and after reset it converts input 1 no matter what is asked. The controller therefore keeps a one-deep queue of issued channel numbers. Every result leaves the block with the tag of the input it actually came from.

While `scan_en` is high, the block walks the inputs enabled in `chan_mask` in ascending order and wraps around at the end. Results leave on a valid/ready stream. A sample stays on the outputs until the consumer takes it. No new frame begins while a sample is waiting, so a stalled consumer pauses the conversions and no data is lost.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is held and right after it, `cs_n` is 1, `sclk` is 1, `mosi` is 0 and `out_valid` is 0.
- R2: Each frame (one `cs_n` low period) contains exactly 16 rising `sclk` edges, and `sclk` is high whenever `cs_n` changes.
- R3: The control byte goes out MSB first on the first 8 rising edges. Bits 4:3 carry the requested channel: 00 is input 1, 01 input 2, 10 input 3, 11 input 4. Bits 7:5 and 2:0 are sent as 0.
- R4: The first result after reset is tagged 0 (input 1).
- R5: Every later result is tagged with the channel code sent in the frame before it.
- R6: With `scan_en` high, requests step through the set bits of `chan_mask` in ascending order and wrap around. The first request after reset is the lowest set bit. An all-zero mask starts no frame.
- R7: `out_data` is made of the last 12 of the 16 bits sampled from `miso` on rising `sclk` edges, MSB first. It is straight binary.
- R8: `out_valid` stays high with `out_data` and `out_ch` stable until `out_ready` is high. No frame starts while a sample is pending.
- R9: Dropping `scan_en` in the middle of a frame lets that frame finish and deliver its sample. After that, no new frame starts.
- R10: Between frames, `cs_n` stays high for at least one `sclk` period (2*DIV system clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Continuous scan enable, checked only between frames |
| chan_mask | input | 4 | Inputs taking part in the scan, bit i = input i+1 |
| out_ready | input | 1 | Consumer accepts the pending sample |
| miso | input | 1 | Serial data from converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to converter |
| out_valid | output | 1 | Sample pending |
| out_data | output | 12 | Conversion result |
| out_ch | output | 2 | Channel tag of the result (0 = input 1) |

## Verification
A frame takes 33*DIV system clocks from the fall of `cs_n`: one half period of setup and then 32 half periods of `sclk`. `out_valid` rises on the same clock edge that raises `cs_n`, which is DIV clocks after the 16th rising `sclk` edge. The bench samples every pin on the falling system clock, half a cycle after the registers update. Its converter model finds the edges by comparing each sample with the one before, so every check is made in the first half-cycle where the new value is visible. The expected data and tags come from the model's own record of what it sent in each frame and of the control byte it received one frame earlier.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int NCH  = 4;
  localparam int CH_W = $clog2(NCH);

  typedef enum logic [1:0] {ST_GAP, ST_IDLE, ST_SETUP, ST_SHIFT} frame_st_e;

  // Request byte: address in bits 4:3, all other bits zero
  function automatic logic [7:0] req_byte(input logic [CH_W-1:0] ch);
    req_byte = {3'b000, ch, 3'b000};
  endfunction
endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 4
) (
  input  logic [$clog2(NCH)-1:0] last,
  input  logic [NCH-1:0]         mask,
  output logic [$clog2(NCH)-1:0] nxt
);
  localparam int CW = $clog2(NCH);
  logic [CW-1:0] cand;
  logic          found;

  always_comb begin
    nxt   = last;
    found = 1'b0;
    cand  = '0;
    for (int i = 1; i <= NCH; i++) begin
      cand = CW'((int'(last) + i) % NCH);
      if (!found && mask[cand]) begin
        nxt   = cand;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int DATA_W     = 12,
  parameter int FRAME_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic [NCH-1:0]    chan_mask,
  input  logic              out_ready,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CH_W-1:0]   out_ch
);
  localparam int HALVES = 2 * FRAME_BITS;
  localparam int HW     = $clog2(HALVES);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALVES - 1);

  frame_st_e           st;
  logic                tick;
  logic                gap_cnt;
  logic [HW-1:0]       half;
  logic [7:0]          tx;
  logic [FRAME_BITS-1:0] rx;
  logic [CH_W-1:0]     conv_ch;   // channel being converted this frame
  logic [CH_W-1:0]     req_ch;    // channel requested this frame
  logic [CH_W-1:0]     last_req;
  logic [CH_W-1:0]     pick;
  logic                can_start;

  adc_sclk_div #(.DIV(DIV)) u_div (.clk(clk), .rst_n(rst_n), .tick(tick));

  adc_chan_pick #(.NCH(NCH)) u_pick (.last(last_req), .mask(chan_mask), .nxt(pick));

  assign can_start = scan_en && (chan_mask != '0) && !out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_GAP;
      gap_cnt   <= 1'b0;
      half      <= '0;
      tx        <= '0;
      rx        <= '0;
      cs_n      <= 1'b1;
      sclk      <= 1'b1;
      mosi      <= 1'b0;
      conv_ch   <= '0;
      req_ch    <= '0;
      last_req  <= CH_W'(NCH - 1);
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ch    <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (tick) begin
        unique case (st)
          ST_GAP: begin
            gap_cnt <= 1'b1;
            if (gap_cnt) st <= ST_IDLE;
          end
          ST_IDLE: begin
            if (can_start) begin
              cs_n     <= 1'b0;
              req_ch   <= pick;
              last_req <= pick;
              tx       <= req_byte(pick);
              st       <= ST_SETUP;
            end
          end
          ST_SETUP: begin
            sclk <= 1'b0;
            mosi <= tx[7];
            tx   <= {tx[6:0], 1'b0};
            half <= '0;
            st   <= ST_SHIFT;
          end
          ST_SHIFT: begin
            if (!half[0]) begin
              sclk <= 1'b1;
              rx   <= {rx[FRAME_BITS-2:0], miso};
              half <= half + 1'b1;
            end else if (half == HALF_LAST) begin
              cs_n      <= 1'b1;
              mosi      <= 1'b0;
              out_valid <= 1'b1;
              out_data  <= rx[DATA_W-1:0];
              out_ch    <= conv_ch;
              conv_ch   <= req_ch;
              gap_cnt   <= 1'b0;
              st        <= ST_GAP;
            end else begin
              sclk <= 1'b0;
              mosi <= tx[7];
              tx   <= {tx[6:0], 1'b0};
              half <= half + 1'b1;
            end
          end
          default: st <= ST_GAP;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int DIV    = 4,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_en,
  input logic [3:0]        chan_mask,
  input logic              out_ready,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [1:0]        out_ch
);
  logic [15:0] hi_cnt;
  logic [5:0]  edge_cnt;
  logic        sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      edge_cnt <= '0;
      sclk_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        edge_cnt <= '0;
        if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (sclk && !sclk_q) edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cs_n && sclk && !mosi && !out_valid));

  a_r2_sclk_high_at_cs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) || $rose(cs_n)) |-> sclk);

  a_r2_sixteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (edge_cnt == 6'd16));

  a_r6_zero_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && chan_mask == 4'd0) |=> cs_n);

  a_r8_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ch)));

  a_r8_no_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cs_n) |=> cs_n);

  a_r9_stop_holds_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !scan_en) |=> cs_n);

  a_r10_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= 16'(2 * DIV)));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.DIV(DIV), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chan_mask(chan_mask),
  .out_ready(out_ready), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .out_valid(out_valid), .out_data(out_data), .out_ch(out_ch)
);

// File: tb/adc_scan_ctrl_tb.sv
module adc_scan_ctrl_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0;
  logic [3:0]  chan_mask = 4'd0;
  logic        out_ready = 1'b1;
  logic        miso = 1'b0;
  logic        cs_n, sclk, mosi, out_valid;
  logic [11:0] out_data;
  logic [1:0]  out_ch;

  always #5 clk = ~clk;

  adc_scan_ctrl #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chan_mask(chan_mask),
    .out_ready(out_ready), .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .out_valid(out_valid), .out_data(out_data), .out_ch(out_ch)
  );

  function automatic int chk_f(input bit ok, input string req, input int act, input int exp);
    if (!ok) $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    return ok ? 0 : 1;
  endfunction

  // converter model
  int          m_chk = 0, m_err = 0;
  int          fidx, rise, gapcnt;
  logic        p_cs, p_sclk;
  logic [1:0]  conv_ch;
  logic [7:0]  ctrl;
  logic [15:0] word;
  logic [11:0] sent_data [64];
  logic [1:0]  sent_ch   [64];

  function automatic logic [11:0] data_of(input int k);
    if (k % 7 == 3) return 12'hFFF;
    if (k % 7 == 5) return 12'h000;
    return 12'h5A3 ^ 12'(k * 299);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      conv_ch = 2'd0; fidx = 0; rise = 0; gapcnt = 0;
      p_cs = 1'b1; p_sclk = 1'b1; miso = 1'b0; ctrl = '0; word = '0;
    end else begin
      if (p_cs && !cs_n) begin
        m_chk++; m_err += chk_f(gapcnt >= 2 * DIV, "R10 gap", gapcnt, 2 * DIV);
        m_chk++; m_err += chk_f(sclk == 1'b1, "R2 sclk at cs fall", sclk, 1);
        word = {4'b0000, data_of(fidx)};
        sent_data[fidx % 64] = word[11:0];
        sent_ch[fidx % 64]   = conv_ch;
        rise = 0; ctrl = '0;
        miso = word[15];
      end
      if (!cs_n && !p_sclk && sclk) begin
        if (rise < 8) ctrl = {ctrl[6:0], mosi};
        rise++;
      end
      if (!cs_n && p_sclk && !sclk && rise < 16) miso = word[15 - rise];
      if (!p_cs && cs_n) begin
        m_chk++; m_err += chk_f(rise == 16, "R2 rising edges", rise, 16);
        m_chk++; m_err += chk_f(sclk == 1'b1, "R2 sclk at cs rise", sclk, 1);
        m_chk++; m_err += chk_f(ctrl[7:5] == 3'd0 && ctrl[2:0] == 3'd0,
                                "R3 zero bits", ctrl, ctrl & 8'h18);
        conv_ch = ctrl[4:3];
        fidx++;
        gapcnt = 0;
      end
      if (cs_n) gapcnt++;
      p_cs = cs_n; p_sclk = sclk;
    end
  end

  // stream consumer
  int         c_chk = 0, c_err = 0;
  int         ridx;
  logic [1:0] got_ch [8];

  always @(negedge clk) begin
    if (!rst_n) ridx = 0;
    else if (out_valid && out_ready) begin
      c_chk++; c_err += chk_f(out_data == sent_data[ridx % 64], "R7 data",
                              out_data, sent_data[ridx % 64]);
      c_chk++; c_err += chk_f(out_ch == sent_ch[ridx % 64], "R5 tag vs model",
                              out_ch, sent_ch[ridx % 64]);
      if (ridx < 8) got_ch[ridx] = out_ch;
      ridx++;
    end
  end

  // main sequence
  int t_chk = 0, t_err = 0, wd_err = 0;

  // {mask, tag0..tag4}
  localparam logic [13:0] VEC [6] = '{
    {4'b1111, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {4'b1010, 2'd0, 2'd1, 2'd3, 2'd1, 2'd3},
    {4'b0100, 2'd0, 2'd2, 2'd2, 2'd2, 2'd2},
    {4'b1000, 2'd0, 2'd3, 2'd3, 2'd3, 2'd3},
    {4'b1001, 2'd0, 2'd0, 2'd3, 2'd0, 2'd3},
    {4'b0010, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1}
  };

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; scan_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic tally(input bit ok, input string req, input int act, input int exp);
    t_chk++; t_err += chk_f(ok, req, act, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks",
             m_err + c_err + t_err + wd_err, m_chk + c_chk + t_chk + wd_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_err = 1;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit cs_fell;
    logic [11:0] held_d;
    logic [1:0]  held_c;
    // R1 reset state
    repeat (3) @(negedge clk);
    tally(cs_n && sclk && !mosi && !out_valid, "R1 in reset",
          {cs_n, sclk, mosi, out_valid}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    tally(cs_n && sclk && !out_valid, "R1 after reset", {cs_n, sclk, out_valid}, 3'b110);

    // scan vectors: R4, R5, R6
    for (int v = 0; v < 6; v++) begin
      do_reset();
      chan_mask = VEC[v][13:10];
      scan_en   = 1'b1;
      while (ridx < 5) @(negedge clk);
      scan_en = 1'b0;
      for (int k = 0; k < 5; k++) begin
        logic [1:0] exp_t;
        exp_t = VEC[v][9 - 2*k -: 2];
        tally(got_ch[k] == exp_t, (k == 0) ? "R4 first tag" : "R6 scan order",
              got_ch[k], exp_t);
      end
    end

    // R8 back-pressure
    do_reset();
    out_ready = 1'b0; chan_mask = 4'b1111; scan_en = 1'b1;
    while (!out_valid) @(negedge clk);
    held_d = out_data; held_c = out_ch; cs_fell = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (!cs_n) cs_fell = 1'b1;
    end
    tally(out_valid && out_data == held_d && out_ch == held_c, "R8 hold",
          out_data, held_d);
    tally(!cs_fell, "R8 no frame while pending", cs_fell, 0);
    out_ready = 1'b1;
    while (ridx < 2) @(negedge clk);
    tally(ridx >= 2, "R8 resume", ridx, 2);
    scan_en = 1'b0;

    // R9 stop mid-frame
    do_reset();
    chan_mask = 4'b0001; scan_en = 1'b1;
    while (cs_n) @(negedge clk);
    repeat (20) @(negedge clk);
    scan_en = 1'b0;
    while (ridx < 1) @(negedge clk);
    cs_fell = 1'b0;
    repeat (500) begin
      @(negedge clk);
      if (!cs_n) cs_fell = 1'b1;
    end
    tally(ridx == 1, "R9 frame completed", ridx, 1);
    tally(!cs_fell && fidx == 1, "R9 no further frame", fidx, 1);

    // R6 zero mask
    do_reset();
    chan_mask = 4'b0000; scan_en = 1'b1;
    repeat (500) @(negedge clk);
    tally(fidx == 0 && cs_n, "R6 zero mask", fidx, 0);
    scan_en = 1'b0;

    summary();
    $finish;
  end
endmodule